// File: doc/BRIEF.md
# Multi-lane code group synchronization controller

This block sits on the receive side of a JESD204B link, after the 8b/10b decoders. Every character clock, each lane presents one decoded octet with a control-character flag and two code-error flags. Each lane has its own tracker. A tracker hunts for an unbroken run of K28.5 comma characters. It declares lock once the run is long enough. It then watches the lane for code errors, and it notes the first data character after the link releases its synchronization request.

The link combines the enabled lanes into one active-low request line toward the converter. The request stays low until every enabled lane is locked. It falls again when a lane loses lock or when the control input forces it low. A lane-enable mask lets the link run on a subset of lanes, down to one lane. A per-lane polarity stage inverts the raw 10-bit symbols before they reach the decoders, which fixes swapped differential pairs. A saturating error count is kept for each lane.

Top module: `cgs_ctrl`

## Requirements
- R1: A character counts as a comma only when its octet is 0xBC, its control flag is 1 and neither error flag is set. The same octet with the control flag at 0 breaks a comma run.
- R2: An enabled lane starts in the hunt state (lane_state code 0). It moves to the locked state (code 1) on the clock edge that samples its fourth consecutive comma. Any non-comma character resets the run.
- R3: After reset, sync_n is 0. One cycle after every enabled lane is out of the hunt state, sync_n rises to 1, provided at least one lane is enabled and no force is active.
- R4: While force_sync_low is 1, sync_n is 0 from the next cycle onward. After the force is removed, sync_n rises one cycle later if all enabled lanes are still locked.
- R5: A disabled lane is held in the hunt state and its error count does not change. Its characters have no effect on sync_n. With no lane enabled, sync_n stays 0.
- R6: A locked or data lane that sees three code errors (disparity or not-in-table) within any four consecutive characters returns to the hunt state. sync_n then falls one cycle later.
- R7: A locked lane that receives an error-free non-comma character while sync_n is 1 moves to the data state (code 2). On that edge it raises its ila_start bit for exactly one cycle.
- R8: A lane in the data state returns to the hunt state on the first edge at which sync_n is 0.
- R9: Each enabled lane's err_cnt adds one for every character with a code error and saturates at 255. An err_clr pulse zeroes all counts and wins over an increment in the same cycle.
- R10: dec_sym carries each lane's rx_sym XORed with all ones when that lane's pol_inv bit is 1, one cycle after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_en | input | LANES | Per-lane enable mask |
| force_sync_low | input | 1 | Holds the sync request low |
| err_clr | input | 1 | Zeroes all lane error counts |
| pol_inv | input | LANES | Per-lane symbol polarity inversion |
| rx_sym | input | LANES*10 | Raw 10-bit symbols from the deserializers |
| dec_sym | output | LANES*10 | Polarity-corrected symbols toward the decoders |
| rx_octet | input | LANES*8 | Decoded octet per lane |
| rx_is_k | input | LANES | Control-character flag per lane |
| rx_disp_err | input | LANES | Disparity error flag per lane |
| rx_nit_err | input | LANES | Not-in-table error flag per lane |
| sync_n | output | 1 | Active-low synchronization request |
| lane_state | output | LANES*2 | Per-lane state: 0 hunt, 1 locked, 2 data |
| ila_start | output | LANES | One-cycle pulse when a lane enters the data state |
| err_cnt | output | LANES*8 | Saturating per-lane code error count |

## Verification
Two functions can land in the same cycle: the clear of the error counters and the count of a fresh code error. The bench provokes this by asserting err_clr in the same character that carries a disparity error, and it expects a count of zero. A window trip can also fall on the edge where sync_n changes. Random streams mix commas, data and errors while toggling the force input, which makes a lane fall out of lock or get promoted to data near a sync_n edge. A cycle model in the bench judges the resulting state, pulse and sync_n values on every cycle.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_LOCKED = 2'd1,
    ST_DATA   = 2'd2
  } cgs_state_e;

  localparam logic [7:0] COMMA_OCTET = 8'hBC;
endpackage

// File: rtl/cgs_polarity.sv
module cgs_polarity #(
  parameter int SYM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inv,
  input  logic [SYM_W-1:0] sym_in,
  output logic [SYM_W-1:0] sym_out
);
  always_ff @(posedge clk) begin
    if (rst) sym_out <= '0;
    else     sym_out <= sym_in ^ {SYM_W{inv}};
  end
endmodule

// File: rtl/cgs_lane.sv
module cgs_lane
  import cgs_pkg::*;
#(
  parameter int MIN_K   = 4,
  parameter int ERR_WIN = 4,
  parameter int ERR_LIM = 3,
  parameter int ECNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sync_n,
  input  logic              err_clr,
  input  logic [7:0]        octet,
  input  logic              is_k,
  input  logic              disp_err,
  input  logic              nit_err,
  output cgs_state_e        state,
  output logic              ila_start,
  output logic [ECNT_W-1:0] err_cnt
);
  localparam int RUN_W  = $clog2(MIN_K + 1);
  localparam int HIST_W = ERR_WIN - 1;
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_K - 1);

  logic [RUN_W-1:0]   run_q;
  logic [HIST_W-1:0]  hist_q;
  logic [ERR_WIN-1:0] win;
  logic               code_err;
  logic               is_comma;
  logic               win_trip;

  assign code_err = disp_err | nit_err;
  assign is_comma = is_k && (octet == COMMA_OCTET) && !code_err;
  assign win      = {hist_q, code_err};
  assign win_trip = ($countones(win) >= ERR_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      run_q     <= '0;
      hist_q    <= '0;
      ila_start <= 1'b0;
      err_cnt   <= '0;
    end else begin
      if (err_clr)
        err_cnt <= '0;
      else if (en && code_err && (err_cnt != {ECNT_W{1'b1}}))
        err_cnt <= err_cnt + 1'b1;

      ila_start <= 1'b0;

      if (!en) begin
        state  <= ST_HUNT;
        run_q  <= '0;
        hist_q <= '0;
      end else begin
        case (state)
          ST_HUNT: begin
            if (is_comma) begin
              if (run_q == RUN_LAST) begin
                state  <= ST_LOCKED;
                run_q  <= '0;
                hist_q <= '0;
              end else begin
                run_q <= run_q + 1'b1;
              end
            end else begin
              run_q <= '0;
            end
          end
          default: begin
            if ((state == ST_DATA) && !sync_n) begin
              state  <= ST_HUNT;
              run_q  <= '0;
              hist_q <= '0;
            end else if (win_trip) begin
              state  <= ST_HUNT;
              run_q  <= '0;
              hist_q <= '0;
            end else begin
              hist_q <= win[HIST_W-1:0];
              if ((state == ST_LOCKED) && sync_n && !is_comma && !code_err) begin
                state     <= ST_DATA;
                ila_start <= 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cgs_link.sv
module cgs_link #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] lane_ready,
  input  logic             force_low,
  output logic             sync_n
);
  logic all_ok;

  assign all_ok = (|lane_en) && (&(lane_ready | ~lane_en));

  always_ff @(posedge clk) begin
    if (rst) sync_n <= 1'b0;
    else     sync_n <= all_ok && !force_low;
  end
endmodule

// File: rtl/cgs_ctrl.sv
module cgs_ctrl
  import cgs_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int SYM_W   = 10,
  parameter int MIN_K   = 4,
  parameter int ERR_WIN = 4,
  parameter int ERR_LIM = 3,
  parameter int ECNT_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES-1:0]      lane_en,
  input  logic                  force_sync_low,
  input  logic                  err_clr,
  input  logic [LANES-1:0]      pol_inv,
  input  logic [LANES*SYM_W-1:0] rx_sym,
  output logic [LANES*SYM_W-1:0] dec_sym,
  input  logic [LANES*8-1:0]    rx_octet,
  input  logic [LANES-1:0]      rx_is_k,
  input  logic [LANES-1:0]      rx_disp_err,
  input  logic [LANES-1:0]      rx_nit_err,
  output logic                  sync_n,
  output logic [LANES*2-1:0]    lane_state,
  output logic [LANES-1:0]      ila_start,
  output logic [LANES*ECNT_W-1:0] err_cnt
);
  cgs_state_e       st_w  [LANES];
  logic [LANES-1:0] ready_w;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    cgs_polarity #(.SYM_W(SYM_W)) u_pol (
      .clk     (clk),
      .rst     (rst),
      .inv     (pol_inv[gl]),
      .sym_in  (rx_sym[gl*SYM_W +: SYM_W]),
      .sym_out (dec_sym[gl*SYM_W +: SYM_W])
    );

    cgs_lane #(
      .MIN_K   (MIN_K),
      .ERR_WIN (ERR_WIN),
      .ERR_LIM (ERR_LIM),
      .ECNT_W  (ECNT_W)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .en        (lane_en[gl]),
      .sync_n    (sync_n),
      .err_clr   (err_clr),
      .octet     (rx_octet[gl*8 +: 8]),
      .is_k      (rx_is_k[gl]),
      .disp_err  (rx_disp_err[gl]),
      .nit_err   (rx_nit_err[gl]),
      .state     (st_w[gl]),
      .ila_start (ila_start[gl]),
      .err_cnt   (err_cnt[gl*ECNT_W +: ECNT_W])
    );

    assign lane_state[gl*2 +: 2] = st_w[gl];
    assign ready_w[gl]           = (st_w[gl] != ST_HUNT);
  end

  cgs_link #(.LANES(LANES)) u_link (
    .clk        (clk),
    .rst        (rst),
    .lane_en    (lane_en),
    .lane_ready (ready_w),
    .force_low  (force_sync_low),
    .sync_n     (sync_n)
  );
endmodule

// File: rtl/cgs_ctrl_chk.sv
module cgs_ctrl_chk #(
  parameter int LANES  = 4,
  parameter int ECNT_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        lane_en,
  input logic                    force_sync_low,
  input logic                    err_clr,
  input logic                    sync_n,
  input logic [LANES*2-1:0]      lane_state,
  input logic [LANES-1:0]        ila_start,
  input logic [LANES*ECNT_W-1:0] err_cnt
);
  logic [LANES-1:0] hunt_v;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_hv
    assign hunt_v[gi] = (lane_state[gi*2 +: 2] == 2'd0);
  end

  AST_FORCE_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    force_sync_low |=> !sync_n); // R4

  AST_HUNT_BLOCKS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (|(lane_en & hunt_v)) |=> !sync_n); // R3

  AST_NO_LANE_NO_SYNC: assert property (@(posedge clk) disable iff (rst)
    (lane_en == '0) |=> !sync_n); // R5

  for (genvar gl = 0; gl < LANES; gl++) begin : g_chk
    AST_ILA_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
      ila_start[gl] |-> (lane_state[gl*2 +: 2] == 2'd2)); // R7

    AST_ILA_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      ila_start[gl] |=> !ila_start[gl]); // R7

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      lane_state[gl*2 +: 2] != 2'd3); // R2

    AST_OFF_LANE_HUNTS: assert property (@(posedge clk) disable iff (rst)
      !lane_en[gl] |=> (lane_state[gl*2 +: 2] == 2'd0)); // R5

    AST_ERR_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
      !err_clr |=> (err_cnt[gl*ECNT_W +: ECNT_W] >= $past(err_cnt[gl*ECNT_W +: ECNT_W]))); // R9

    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
      err_clr |=> (err_cnt[gl*ECNT_W +: ECNT_W] == '0)); // R9

    AST_DATA_DROPS_ON_SYNC_LOW: assert property (@(posedge clk) disable iff (rst)
      (lane_state[gl*2 +: 2] == 2'd2 && !sync_n && lane_en[gl]) |=> (lane_state[gl*2 +: 2] == 2'd0)); // R8
  end
endmodule

bind cgs_ctrl cgs_ctrl_chk #(.LANES(LANES), .ECNT_W(ECNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .lane_en        (lane_en),
  .force_sync_low (force_sync_low),
  .err_clr        (err_clr),
  .sync_n         (sync_n),
  .lane_state     (lane_state),
  .ila_start      (ila_start),
  .err_cnt        (err_cnt)
);

// File: tb/cgs_ctrl_bench.sv
module cgs_ctrl_bench;
  localparam int L = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [L-1:0]  lane_en, pol_inv, rx_k, rx_disp, rx_nit, ila_start;
  logic          force_low, err_clr, sync_n;
  logic [L*10-1:0] rx_sym, dec_sym;
  logic [L*8-1:0]  rx_octet, err_cnt;
  logic [L*2-1:0]  lane_state;

  int nchk = 0;
  int nbad = 0;

  logic [1:0] m_st   [L];
  int         m_run  [L];
  logic [2:0] m_hist [L];
  logic       m_ila  [L];
  int         m_errc [L];
  logic       m_sync;
  logic [L*10-1:0] m_dec;

  always #2.5 clk = ~clk;

  cgs_ctrl u_cgs_ctrl (
    .clk(clk), .rst(rst), .lane_en(lane_en), .force_sync_low(force_low),
    .err_clr(err_clr), .pol_inv(pol_inv), .rx_sym(rx_sym), .dec_sym(dec_sym),
    .rx_octet(rx_octet), .rx_is_k(rx_k), .rx_disp_err(rx_disp), .rx_nit_err(rx_nit),
    .sync_n(sync_n), .lane_state(lane_state), .ila_start(ila_start), .err_cnt(err_cnt)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_lane(input int l, input logic [7:0] oc, input logic k, input logic d, input logic n);
    rx_octet[l*8 +: 8] = oc;
    rx_k[l]    = k;
    rx_disp[l] = d;
    rx_nit[l]  = n;
  endtask

  task automatic all_comma();
    for (int l = 0; l < L; l++) set_lane(l, 8'hBC, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic model_reset();
    for (int l = 0; l < L; l++) begin
      m_st[l] = 2'd0; m_run[l] = 0; m_hist[l] = 3'd0; m_ila[l] = 1'b0; m_errc[l] = 0;
    end
    m_sync = 1'b0;
    m_dec  = '0;
  endtask

  task automatic model_step();
    logic ok_all = 1'b1;
    logic any_en = 1'b0;
    logic nsync;
    for (int l = 0; l < L; l++)
      if (lane_en[l]) begin
        any_en = 1'b1;
        if (m_st[l] == 2'd0) ok_all = 1'b0;
      end
    nsync = any_en && ok_all && !force_low;
    for (int l = 0; l < L; l++) begin
      logic [7:0] oc;
      logic e, c;
      oc = rx_octet[l*8 +: 8];
      e  = rx_disp[l] | rx_nit[l];
      c  = rx_k[l] && (oc == 8'hBC) && !e;
      if (err_clr) m_errc[l] = 0;
      else if (lane_en[l] && e && m_errc[l] < 255) m_errc[l]++;
      m_ila[l] = 1'b0;
      if (!lane_en[l]) begin
        m_st[l] = 2'd0; m_run[l] = 0; m_hist[l] = 3'd0;
      end else if (m_st[l] == 2'd0) begin
        if (c) begin
          if (m_run[l] == 3) begin m_st[l] = 2'd1; m_run[l] = 0; m_hist[l] = 3'd0; end
          else m_run[l]++;
        end else m_run[l] = 0;
      end else if ((m_st[l] == 2'd2 && !m_sync) || ($countones({m_hist[l], e}) >= 3)) begin
        m_st[l] = 2'd0; m_run[l] = 0; m_hist[l] = 3'd0;
      end else begin
        m_hist[l] = {m_hist[l][1:0], e};
        if (m_st[l] == 2'd1 && m_sync && !c && !e) begin m_st[l] = 2'd2; m_ila[l] = 1'b1; end
      end
      m_dec[l*10 +: 10] = rx_sym[l*10 +: 10] ^ {10{pol_inv[l]}};
    end
    m_sync = nsync;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
    chk(sync_n == m_sync, "R3 sync_n vs model", 64'(sync_n), 64'(m_sync));
    chk(dec_sym == m_dec, "R10 dec_sym vs model", 64'(dec_sym), 64'(m_dec));
    for (int l = 0; l < L; l++) begin
      chk(lane_state[l*2 +: 2] == m_st[l], "R2 lane_state vs model", 64'(lane_state[l*2 +: 2]), 64'(m_st[l]));
      chk(ila_start[l] == m_ila[l], "R7 ila_start vs model", 64'(ila_start[l]), 64'(m_ila[l]));
      chk(err_cnt[l*8 +: 8] == 8'(m_errc[l]), "R9 err_cnt vs model", 64'(err_cnt[l*8 +: 8]), 64'(m_errc[l]));
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    void'($urandom(32'd2024));
    rst = 1'b1; lane_en = '1; pol_inv = '0; force_low = 1'b0; err_clr = 1'b0;
    rx_sym = '0; all_comma();
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sync_n == 1'b0, "R3 reset sync_n", 64'(sync_n), 0);
    chk(lane_state == '0, "R2 reset state", 64'(lane_state), 0);
    chk(err_cnt == '0, "R9 reset err_cnt", 64'(err_cnt), 0);
    rst = 1'b0;

    // R1/R2: comma runs, one lane broken by an unflagged 0xBC
    repeat (3) step();
    chk(lane_state == 8'h00, "R2 still hunting after 3", 64'(lane_state), 0);
    set_lane(0, 8'hBC, 1'b0, 1'b0, 1'b0);
    step();
    chk(lane_state == 8'h54, "R1 flagless BC breaks run", 64'(lane_state), 64'h54);
    all_comma();
    repeat (3) step();
    chk(sync_n == 1'b0, "R3 waits for last lane", 64'(sync_n), 0);
    step();
    chk(lane_state == 8'h55, "R2 all locked", 64'(lane_state), 64'h55);
    chk(sync_n == 1'b0, "R3 one cycle after lock", 64'(sync_n), 0);
    step();
    chk(sync_n == 1'b1, "R3 released", 64'(sync_n), 1);

    // R7: first data character
    for (int l = 0; l < L; l++) set_lane(l, 8'h5A, 1'b0, 1'b0, 1'b0);
    step();
    chk(ila_start == 4'hF, "R7 ila pulse", 64'(ila_start), 64'hF);
    chk(lane_state == 8'hAA, "R7 data state", 64'(lane_state), 64'hAA);
    step();
    chk(ila_start == 4'h0, "R7 pulse single", 64'(ila_start), 0);

    // R6: two errors in a window keep lock, three drop it
    set_lane(0, 8'h11, 1'b0, 1'b1, 1'b0); step(); step();
    set_lane(0, 8'h11, 1'b0, 1'b0, 1'b0); step(); step();
    set_lane(0, 8'h11, 1'b0, 1'b0, 1'b1); step(); step();
    chk(lane_state[1:0] == 2'd2, "R6 two in four tolerated", 64'(lane_state[1:0]), 2);
    step();
    chk(lane_state[1:0] == 2'd0, "R6 three in four drop", 64'(lane_state[1:0]), 0);
    chk(sync_n == 1'b1, "R6 sync lags one cycle", 64'(sync_n), 1);
    set_lane(0, 8'h11, 1'b0, 1'b0, 1'b0);
    step();
    chk(sync_n == 1'b0, "R6 sync falls", 64'(sync_n), 0);
    step();
    chk(lane_state == 8'h00, "R8 data lanes rehunt", 64'(lane_state), 0);
    chk(err_cnt[7:0] == 8'd5, "R9 error tally", 64'(err_cnt[7:0]), 5);

    // R4: force low
    all_comma();
    repeat (5) step();
    chk(sync_n == 1'b1, "R4 relocked", 64'(sync_n), 1);
    force_low = 1'b1;
    step();
    chk(sync_n == 1'b0, "R4 forced low", 64'(sync_n), 0);
    repeat (3) step();
    chk(sync_n == 1'b0, "R4 stays forced", 64'(sync_n), 0);
    force_low = 1'b0;
    step();
    chk(sync_n == 1'b1, "R4 released", 64'(sync_n), 1);

    // R9: clear coincides with a new error
    err_clr = 1'b1;
    set_lane(2, 8'h00, 1'b0, 1'b1, 1'b0);
    step();
    err_clr = 1'b0;
    chk(err_cnt == '0, "R9 clear beats increment", 64'(err_cnt), 0);

    // R5: single-lane operation, disabled lanes ignored
    lane_en = 4'b0001;
    all_comma();
    for (int l = 1; l < L; l++) set_lane(l, 8'h77, 1'b1, 1'b1, 1'b1);
    snap = err_cnt[31:24];
    repeat (6) step();
    chk(err_cnt[31:24] == snap, "R5 disabled lane no count", 64'(err_cnt[31:24]), 64'(snap));
    chk(lane_state[7:2] == '0, "R5 disabled lanes hunt", 64'(lane_state[7:2]), 0);
    chk(sync_n == 1'b1, "R5 single lane link", 64'(sync_n), 1);
    lane_en = '0;
    repeat (3) step();
    chk(sync_n == 1'b0, "R5 no lanes no sync", 64'(sync_n), 0);

    // R9: saturation
    lane_en = '1;
    all_comma();
    set_lane(1, 8'h33, 1'b0, 1'b1, 1'b0);
    repeat (300) step();
    chk(err_cnt[15:8] == 8'd255, "R9 saturates", 64'(err_cnt[15:8]), 255);

    // R10: polarity
    pol_inv = 4'b0101;
    rx_sym = 40'h3_55AA_0F0F;
    step();
    chk(dec_sym == (40'h3_55AA_0F0F ^ {10'h000, 10'h3FF, 10'h000, 10'h3FF}),
        "R10 inversion", 64'(dec_sym), 64'(40'h3_55AA_0F0F ^ {10'h000, 10'h3FF, 10'h000, 10'h3FF}));

    // random phases: comma-heavy and mixed
    for (int i = 0; i < 4000; i++) begin
      bit quiet;
      quiet = ((i / 40) % 2) == 0;
      lane_en   = ($urandom % 20 == 0) ? 4'($urandom) : 4'hF;
      force_low = ($urandom % 60 == 0);
      err_clr   = ($urandom % 100 == 0);
      pol_inv   = 4'($urandom);
      rx_sym    = {8'($urandom), 32'($urandom)};
      for (int l = 0; l < L; l++) begin
        int r;
        r = $urandom % 100;
        if (quiet) begin
          if (r < 97) set_lane(l, 8'hBC, 1'b1, 1'b0, 1'b0);
          else        set_lane(l, 8'h21, 1'b0, 1'b1, 1'b0);
        end else if (r < 60) set_lane(l, 8'hBC, 1'b1, 1'b0, 1'b0);
        else if (r < 84) set_lane(l, 8'($urandom), 1'b0, 1'b0, 1'b0);
        else if (r < 91) set_lane(l, 8'($urandom), 1'b0, 1'b1, 1'b0);
        else if (r < 95) set_lane(l, 8'($urandom), 1'b1, 1'b0, 1'b1);
        else             set_lane(l, 8'h7C, 1'b1, 1'b0, 1'b0);
      end
      step();
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule